// File: doc/BRIEF.md
# Monochrome-to-Color Expansion Write Unit

This unit sits in the CPU write path ahead of video memory. It turns one-bit-per-pixel data into color pixels. Each write covers eight pixels, and each pixel has a select bit. A set select bit gives the pixel the foreground color and a clear one gives it the background color. The select byte comes from one of two places: the low byte of the CPU write data, or a stored pattern register.

The result is a 64-bit memory word with an 8-bit byte-enable. In packed mode each byte lane holds one 8-bit pixel. In planar mode each byte lane holds one color plane, with one bit per pixel. An optional pixel mask gates the write. It acts on pixels in packed mode and on planes in planar mode. An ordering bit reverses how select and mask bits map onto pixels. When expansion is off, the CPU word and its byte enables pass through unchanged. Every CPU write strobe produces a registered output one cycle later.

Top module: `cexp_unit`

## Requirements
- R1: After reset, wr_valid_o, wr_data_o and wr_be_o are all zero, and every register is zero, so expansion starts disabled.
- R2: With control bit 0 (enable) clear, a strobed write outputs cpu_data_i and cpu_be_i unchanged.
- R3: wr_valid_o is high in exactly the cycle after each cycle with cpu_we_i high. wr_data_o and wr_be_o hold their values when no strobe occurs.
- R4: In packed mode (control bit 1 clear) with expansion enabled, byte lane k (bits 8k+7:8k) equals the foreground register (address 1) when pixel k's select bit is 1, and the background register (address 2) otherwise.
- R5: With control bit 2 clear, the select byte is cpu_data_i[7:0]. With it set, the select byte is the pattern register (address 3).
- R6: With control bit 4 (order) clear, pixel k uses select bit k and mask bit k. With it set, pixel k uses bit 7-k of both.
- R7: In planar mode (control bit 1 set), bit k of byte lane p equals bit p of the foreground register when pixel k's select bit is 1, and bit p of the background register otherwise.
- R8: With control bit 3 (mask enable) set during expansion, wr_be_o bit k equals the mask register (address 4) bit that R6 assigns to index k. With control bit 3 clear, wr_be_o is 8'hFF.
- R9: In planar mode with the mask enabled, the mask gates whole planes: wr_be_o bit p enables byte lane p, using the same bit mapping as R6.
- R10: Register writes to addresses 5 to 7 change no register.
- R11: When a register write and a CPU strobe fall in the same cycle, the CPU write uses the register values from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address: 0 control, 1 foreground, 2 background, 3 pattern, 4 mask |
| reg_wdata_i | input | 8 | Register write data |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_data_i | input | 64 | CPU write data; the low byte supplies the select bits |
| cpu_be_i | input | 8 | CPU byte enables, used when expansion is off |
| wr_valid_o | output | 1 | Memory write valid |
| wr_data_o | output | 64 | Memory write data |
| wr_be_o | output | 8 | Memory write byte enables |

## Verification
The hardest case to reach is the interaction of the planar transpose with reversed ordering and an active mask. There, one select bit has to appear in the same bit position across all eight planes, while the mask acts on planes instead of pixels. Random runs reprogram every register between CPU writes, so all 32 combinations of the control bits are visited with random colors, patterns and masks. Directed cases add the remaining corners: a register write landing in the same cycle as a CPU strobe, writes to unmapped addresses, and foreground equal to background.

// File: rtl/cexp_pkg.sv
package cexp_pkg;
  localparam int unsigned PIX = 8;
  localparam int unsigned CW  = 8;
  localparam int unsigned DW  = PIX * CW;

  typedef enum logic [2:0] {
    ADDR_CTRL = 3'd0,
    ADDR_FG   = 3'd1,
    ADDR_BG   = 3'd2,
    ADDR_PAT  = 3'd3,
    ADDR_MASK = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic order;
    logic mask_en;
    logic pat_src;
    logic planar;
    logic en;
  } ctrl_t;

  typedef struct packed {
    ctrl_t          ctrl;
    logic [CW-1:0]  fg;
    logic [CW-1:0]  bg;
    logic [PIX-1:0] pat;
    logic [PIX-1:0] mask;
  } cfg_t;
endpackage

// File: rtl/cexp_regs.sv
module cexp_regs
  import cexp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [7:0]    wdata_i,
  output cfg_t          cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_CTRL: cfg_q.ctrl <= ctrl_t'(wdata_i[4:0]);
        ADDR_FG:   cfg_q.fg   <= wdata_i[CW-1:0];
        ADDR_BG:   cfg_q.bg   <= wdata_i[CW-1:0];
        ADDR_PAT:  cfg_q.pat  <= wdata_i[PIX-1:0];
        ADDR_MASK: cfg_q.mask <= wdata_i[PIX-1:0];
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;

  a_r10_unmapped_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i > 3'd4) |=> $stable(cfg_q));
endmodule

// File: rtl/cexp_expand.sv
module cexp_expand
  import cexp_pkg::*;
(
  input  logic [PIX-1:0] src_i,
  input  logic           order_i,
  input  logic           planar_i,
  input  logic [CW-1:0]  fg_i,
  input  logic [CW-1:0]  bg_i,
  output logic [DW-1:0]  data_o
);
  logic [PIX-1:0] sel;
  logic [DW-1:0]  packed_w;
  logic [DW-1:0]  planar_w;

  for (genvar k = 0; k < PIX; k++) begin : g_pix
    assign sel[k] = order_i ? src_i[PIX-1-k] : src_i[k];
    assign packed_w[k*CW +: CW] = sel[k] ? fg_i : bg_i;
  end

  // planar: lane p collects color bit p of every pixel
  for (genvar p = 0; p < CW; p++) begin : g_plane
    for (genvar k = 0; k < PIX; k++) begin : g_bit
      assign planar_w[p*PIX + k] = sel[k] ? fg_i[p] : bg_i[p];
    end
  end

  assign data_o = planar_i ? planar_w : packed_w;
endmodule

// File: rtl/cexp_mask.sv
module cexp_mask
  import cexp_pkg::*;
(
  input  logic           mask_en_i,
  input  logic           order_i,
  input  logic [PIX-1:0] mask_i,
  output logic [PIX-1:0] be_o
);
  for (genvar k = 0; k < PIX; k++) begin : g_be
    assign be_o[k] = !mask_en_i || (order_i ? mask_i[PIX-1-k] : mask_i[k]);
  end
endmodule

// File: rtl/cexp_unit.sv
module cexp_unit
  import cexp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  input  logic          cpu_we_i,
  input  logic [63:0]   cpu_data_i,
  input  logic [7:0]    cpu_be_i,
  output logic          wr_valid_o,
  output logic [63:0]   wr_data_o,
  output logic [7:0]    wr_be_o
);
  cfg_t           cfg;
  logic [PIX-1:0] src;
  logic [DW-1:0]  exp_data;
  logic [PIX-1:0] exp_be;
  logic [DW-1:0]  data_n;
  logic [PIX-1:0] be_n;

  cexp_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .cfg_o   (cfg)
  );

  assign src = cfg.ctrl.pat_src ? cfg.pat : cpu_data_i[PIX-1:0];

  cexp_expand u_expand (
    .src_i    (src),
    .order_i  (cfg.ctrl.order),
    .planar_i (cfg.ctrl.planar),
    .fg_i     (cfg.fg),
    .bg_i     (cfg.bg),
    .data_o   (exp_data)
  );

  cexp_mask u_mask (
    .mask_en_i (cfg.ctrl.mask_en),
    .order_i   (cfg.ctrl.order),
    .mask_i    (cfg.mask),
    .be_o      (exp_be)
  );

  assign data_n = cfg.ctrl.en ? exp_data : cpu_data_i;
  assign be_n   = cfg.ctrl.en ? exp_be   : cpu_be_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o <= 1'b0;
      wr_data_o  <= '0;
      wr_be_o    <= '0;
    end else begin
      wr_valid_o <= cpu_we_i;
      if (cpu_we_i) begin
        wr_data_o <= data_n;
        wr_be_o   <= be_n;
      end
    end
  end

  a_r3_valid_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i |=> wr_valid_o);
  a_r3_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_we_i |=> (!wr_valid_o && $stable(wr_data_o) && $stable(wr_be_o)));
  a_r2_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && !cfg.ctrl.en) |=>
      (wr_data_o == $past(cpu_data_i) && wr_be_o == $past(cpu_be_i)));
  a_r8_full_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cfg.ctrl.en && !cfg.ctrl.mask_en) |=> (wr_be_o == 8'hFF));
  a_r4_uniform_color: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cfg.ctrl.en && !cfg.ctrl.planar && cfg.fg == cfg.bg) |=>
      (wr_data_o == {PIX{$past(cfg.fg)}}));
endmodule

// File: tb/cexp_unit_tb_top.sv
module cexp_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [63:0] cpu_data = '0;
  logic [7:0]  cpu_be = '0;
  logic        wr_valid;
  logic [63:0] wr_data;
  logic [7:0]  wr_be;

  int checks = 0;
  int errors = 0;
  logic [7:0] s_ctrl = 0, s_fg = 0, s_bg = 0, s_pat = 0, s_mask = 0;

  always #10 clk = ~clk;

  cexp_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .cpu_we_i(cpu_we), .cpu_data_i(cpu_data),
    .cpu_be_i(cpu_be), .wr_valid_o(wr_valid), .wr_data_o(wr_data), .wr_be_o(wr_be)
  );

  function automatic logic [63:0] f_data(logic [63:0] d);
    logic [7:0] src = s_ctrl[2] ? s_pat : d[7:0];
    logic [63:0] r = '0;
    if (!s_ctrl[0]) return d;
    for (int k = 0; k < 8; k++) begin
      logic s = s_ctrl[4] ? src[7-k] : src[k];
      if (!s_ctrl[1]) r[k*8 +: 8] = s ? s_fg : s_bg;
      else for (int p = 0; p < 8; p++) r[p*8+k] = s ? s_fg[p] : s_bg[p];
    end
    return r;
  endfunction

  function automatic logic [7:0] f_be(logic [7:0] be);
    logic [7:0] r;
    if (!s_ctrl[0]) return be;
    if (!s_ctrl[3]) return 8'hFF;
    for (int k = 0; k < 8; k++) r[k] = s_ctrl[4] ? s_mask[7-k] : s_mask[k];
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shadow(logic [2:0] a, logic [7:0] d);
    case (a)
      3'd0: s_ctrl = {3'b0, d[4:0]};
      3'd1: s_fg = d;
      3'd2: s_bg = d;
      3'd3: s_pat = d;
      3'd4: s_mask = d;
      default: ;
    endcase
  endtask

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    shadow(a, d);
  endtask

  task automatic cpu_wr(string req, logic [63:0] d, logic [7:0] be);
    logic [63:0] ed;
    logic [7:0]  eb;
    @(negedge clk);
    cpu_we = 1; cpu_data = d; cpu_be = be;
    ed = f_data(d); eb = f_be(be);
    @(negedge clk);
    cpu_we = 0;
    chk({req, " valid"}, 64'(wr_valid), 64'd1);
    chk({req, " data"}, wr_data, ed);
    chk({req, " be"}, 64'(wr_be), 64'(eb));
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #25 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", 64'(wr_valid), 0);
    chk("R1 data", wr_data, 0);
    chk("R1 be", 64'(wr_be), 0);
    // R2 pass-through with expansion off after reset
    cpu_wr("R2", 64'h0123_4567_89AB_CDEF, 8'h5A);
    // R3 idle cycle: valid drops, data holds
    @(negedge clk);
    chk("R3 idle valid", 64'(wr_valid), 0);
    chk("R3 hold data", wr_data, 64'h0123_4567_89AB_CDEF);
    // R4 packed, CPU source, natural order
    wr_reg(1, 8'hC3); wr_reg(2, 8'h18); wr_reg(0, 8'h01);
    cpu_wr("R4", 64'hA5, 8'h00);
    chk("R4 lane0", 64'(wr_data[7:0]), 64'hC3);
    chk("R4 lane1", 64'(wr_data[15:8]), 64'h18);
    // R5 pattern source
    wr_reg(3, 8'h0F); wr_reg(0, 8'h05);
    cpu_wr("R5", 64'hF0, 8'h00);
    // R6 reversed order with mask
    wr_reg(4, 8'h01); wr_reg(0, 8'h19);
    cpu_wr("R6", 64'h00, 8'h00);
    chk("R6 be bit7", 64'(wr_be), 64'h80);
    // R7/R9 planar with reversed mask
    wr_reg(0, 8'h1B);
    cpu_wr("R7", 64'h00, 8'h00);
    wr_reg(4, 8'h3C); wr_reg(0, 8'h0B);
    cpu_wr("R9", 64'h00, 8'h00);
    // R8 mask disabled -> all enables
    wr_reg(0, 8'h01);
    cpu_wr("R8", 64'h77, 8'h00);
    // R10 unmapped addresses leave registers alone
    wr_reg(5, 8'hFF); wr_reg(6, 8'h00); wr_reg(7, 8'h1F);
    cpu_wr("R10", 64'h5A, 8'h00);
    // R4 foreground equal to background
    wr_reg(2, 8'hC3);
    cpu_wr("R4 uniform", 64'h3C, 8'h00);
    // R11 same-cycle register and CPU write
    begin
      logic [63:0] ed;
      @(negedge clk);
      reg_we = 1; reg_addr = 3'd1; reg_wdata = 8'h99;
      cpu_we = 1; cpu_data = 64'hFF; cpu_be = 0;
      ed = f_data(64'hFF);
      @(negedge clk);
      reg_we = 0; cpu_we = 0;
      shadow(3'd1, 8'h99);
      chk("R11 old fg", wr_data, ed);
      cpu_wr("R11 new fg", 64'hFF, 8'h00);
    end
    // random mix
    for (int i = 0; i < 400; i++) begin
      int n = $urandom_range(0, 3);
      for (int j = 0; j < n; j++)
        wr_reg(3'($urandom_range(0, 7)), 8'($urandom));
      cpu_wr("R4-R9 random", {$urandom, $urandom}, 8'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule